// File: doc/BRIEF.md
# Timebase Divider with Tone Output

This block is a free-running binary divider that serves as a chip's timebase. Its input can be one of three tick strobes, chosen at run time: a slow sub-clock tick (nominally 32.768 kHz), the system clock tick, or the prescaler output of another timer. A fourth select code stops the count.

Two events are taken from the same counter. The long event fires once per full wrap of the counter, which is 0.5 s at 32.768 kHz with the default 14-bit width. The short event fires once per wrap of a selectable group of low bits. At 32.768 kHz its four choices give about 0.98 ms, 3.9 ms, 15.6 ms or 62.5 ms.

Each event sets its own sticky flag. Software clears a flag with a one-cycle clear strobe. Each flag has an enable that passes it to a shared interrupt request, which the surrounding logic shares with an external interrupt line. A square-wave tone output, also tapped from the counter, gives input/8 (4 kHz) or input/16 (2 kHz) and is held low when the tone is off.

Top module: `tick_base_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, both flags, `irq` and `tone` go low. The source register goes to code 0.
- R2: `src_sel` picks which tick strobe advances the counter: 0 = `sub_tick`, 1 = `sys_tick`, 2 = `pre_tick`, 3 = none. Strobes from unselected sources have no effect on the count.
- R3: `long_flag` is set on the accepted tick that carries the counter from all ones to zero, which is once every 2^CNT_W accepted ticks.
- R4: `short_flag` is set on an accepted tick taken while the low K counter bits are all ones, with K = SHORT_BASE + SHORT_STEP*`short_sel`. This gives a period of 2^K ticks.
- R5: A clock edge at which `src_sel` differs from the registered source clears the counter and loads the new source. Any tick in that cycle is ignored, and no flag is set in that cycle.
- R6: With `tone_en` high, `tone` equals counter bit BUZ_BASE when `tone_low` is 0, and counter bit BUZ_BASE+1 when `tone_low` is 1. These give square waves of period 2^(BUZ_BASE+1) and 2^(BUZ_BASE+2) ticks.
- R7: With `tone_en` low, `tone` is low.
- R8: Each flag stays set until its clear strobe is high at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R9: `irq` is high exactly when (`long_flag` and `long_ie`) or (`short_flag` and `short_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_tick | input | 1 | Sub-clock tick strobe |
| sys_tick | input | 1 | System clock tick strobe |
| pre_tick | input | 1 | Other timer's prescaler strobe |
| src_sel | input | 2 | Source code (0 sub, 1 sys, 2 prescaler, 3 stop) |
| short_sel | input | 2 | Short period choice |
| tone_en | input | 1 | Tone output enable |
| tone_low | input | 1 | Tone pitch: 0 high, 1 low |
| long_ie | input | 1 | Long flag interrupt enable |
| short_ie | input | 1 | Short flag interrupt enable |
| long_clr | input | 1 | Long flag clear strobe |
| short_clr | input | 1 | Short flag clear strobe |
| long_flag | output | 1 | Sticky long overflow flag |
| short_flag | output | 1 | Sticky short overflow flag |
| irq | output | 1 | Enabled-flag interrupt request |
| tone | output | 1 | Square-wave tone output |

## Verification
The bench builds the block with CNT_W = 8, SHORT_BASE = 2, SHORT_STEP = 1 and BUZ_BASE = 1. This shrinks the long period to 256 ticks and the short periods to 4, 8, 16 and 32 ticks. Many full counter wraps therefore occur inside every combination of source, short period, tone pitch and enable. Mid-run source changes, random tick strobes on all three inputs, and clear strobes that collide with set events are compared cycle by cycle against a count kept arithmetically in the bench.

// File: rtl/bt_pkg.sv
// Shared encodings for the timebase divider.
// Assumes a 2-bit source select; code 3 stops the count.
package bt_pkg;
    typedef enum logic [1:0] {
        SRC_SUB  = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_PRE  = 2'd2,
        SRC_STOP = 2'd3
    } src_e;
endpackage

// File: rtl/bt_src_sel.sv
// Input selector: registers the chosen source and passes only its tick.
// Assumes tick strobes are single-cycle and synchronous to clk.
// A select change produces a resync cycle in which no tick is accepted.
module bt_src_sel
    import bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       sub_tick,
    input  logic       sys_tick,
    input  logic       pre_tick,
    output logic [1:0] src_q,
    output logic       resync,
    output logic       adv
);
    logic sel_tick;

    // Hold the active source; reload it on every change.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= SRC_SUB;
        else        src_q <= src_sel;
    end

    // Route the tick of the active source.
    always_comb begin
        case (src_e'(src_q))
            SRC_SUB: sel_tick = sub_tick;
            SRC_SYS: sel_tick = sys_tick;
            SRC_PRE: sel_tick = pre_tick;
            default: sel_tick = 1'b0;
        endcase
    end

    // Flag a change and suppress the tick in that cycle.
    always_comb begin
        resync = (src_sel != src_q);
        adv    = sel_tick && !resync;
    end
endmodule

// File: rtl/bt_divider.sv
// Free-running binary counter with a full-wrap event and a selectable
// low-bit wrap event. Assumes SHORT_BASE >= 1 and that the longest
// short tap stays below CNT_W.
module bt_divider #(
    parameter int CNT_W      = 14,
    parameter int SHORT_BASE = 5,
    parameter int SHORT_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             resync,
    input  logic [1:0]       short_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             long_ev,
    output logic             short_ev
);
    localparam int N_OPT = 4;
    logic [N_OPT-1:0] low_full;

    // Count accepted ticks; clear on reset or source change.
    always_ff @(posedge clk) begin
        if (!rst_n || resync) cnt <= '0;
        else if (adv)         cnt <= cnt + 1'b1;
    end

    // One detector per short period option.
    for (genvar i = 0; i < N_OPT; i++) begin : g_tap
        localparam int K = SHORT_BASE + SHORT_STEP * i;
        assign low_full[i] = &cnt[K-1:0];
    end

    // Wrap events occur on the tick that leaves the all-ones state.
    always_comb begin
        long_ev  = adv && (&cnt);
        short_ev = adv && low_full[short_sel];
    end
endmodule

// File: rtl/bt_flags.sv
// Sticky event flags with clear strobes and a gated interrupt request.
// A set on the same edge as a clear takes precedence.
module bt_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flag,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Set on event, else clear on strobe, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)         flag[i] <= 1'b0;
            else if (set_ev[i]) flag[i] <= 1'b1;
            else if (clr[i])    flag[i] <= 1'b0;
        end
    end

    // Combine enabled flags into one request.
    always_comb irq = |(flag & ie);
endmodule

// File: rtl/tick_base_timer.sv
// Timebase top: source selector, shared divider, event flags and a tone
// tap. Assumes all strobes are synchronous to clk.
module tick_base_timer #(
    parameter int CNT_W      = 14,
    parameter int SHORT_BASE = 5,
    parameter int SHORT_STEP = 2,
    parameter int BUZ_BASE   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic       sys_tick,
    input  logic       pre_tick,
    input  logic [1:0] src_sel,
    input  logic [1:0] short_sel,
    input  logic       tone_en,
    input  logic       tone_low,
    input  logic       long_ie,
    input  logic       short_ie,
    input  logic       long_clr,
    input  logic       short_clr,
    output logic       long_flag,
    output logic       short_flag,
    output logic       irq,
    output logic       tone
);
    localparam int HI_BIT = BUZ_BASE;
    localparam int LO_BIT = BUZ_BASE + 1;

    logic [1:0]       src_q;
    logic             resync;
    logic             adv;
    logic [CNT_W-1:0] cnt;
    logic             long_ev;
    logic             short_ev;
    logic [1:0]       flag_v;

    bt_src_sel i_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .sub_tick (sub_tick),
        .sys_tick (sys_tick),
        .pre_tick (pre_tick),
        .src_q    (src_q),
        .resync   (resync),
        .adv      (adv)
    );

    bt_divider #(
        .CNT_W      (CNT_W),
        .SHORT_BASE (SHORT_BASE),
        .SHORT_STEP (SHORT_STEP)
    ) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .resync    (resync),
        .short_sel (short_sel),
        .cnt       (cnt),
        .long_ev   (long_ev),
        .short_ev  (short_ev)
    );

    bt_flags #(.N(2)) i_flg (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev ({short_ev, long_ev}),
        .clr    ({short_clr, long_clr}),
        .ie     ({short_ie, long_ie}),
        .flag   (flag_v),
        .irq    (irq)
    );

    // Split flags to ports and pick the tone tap.
    always_comb begin
        long_flag  = flag_v[0];
        short_flag = flag_v[1];
        tone       = tone_en && (tone_low ? cnt[LO_BIT] : cnt[HI_BIT]);
    end
endmodule

// File: rtl/tick_base_timer_chk.sv
// Property checker for the timebase, attached to every instance by bind.
module tick_base_timer_chk #(
    parameter int CNT_W      = 14,
    parameter int SHORT_BASE = 5,
    parameter int SHORT_STEP = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       src_sel,
    input logic [1:0]       short_sel,
    input logic             tone_en,
    input logic             tone_low,
    input logic             long_clr,
    input logic             short_clr,
    input logic             long_flag,
    input logic             short_flag,
    input logic             irq,
    input logic             tone,
    input logic [CNT_W-1:0] cnt
);
    function automatic logic low_zero(logic [CNT_W-1:0] c, logic [1:0] s);
        int k;
        k = SHORT_BASE + SHORT_STEP * int'(s);
        for (int b = 0; b < CNT_W; b++) begin
            if (b < k && c[b]) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!long_flag && !short_flag && !irq && cnt == '0));

    // R3
    long_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_flag) |-> (cnt == '0));

    // R4
    short_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_flag) |-> low_zero(cnt, $past(short_sel)));

    // R5
    resync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel != $past(src_sel)) |=> (!$rose(short_flag) && !$rose(long_flag)));

    // R6
    tone_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_en && $stable(tone_en) && $stable(tone_low) && $stable(cnt))
        |-> $stable(tone));

    // R7
    tone_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_en |-> !tone);

    // R8
    long_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (long_flag && !long_clr) |=> long_flag);

    // R8
    short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_flag && !short_clr) |=> short_flag);

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!long_flag && !short_flag) |-> !irq);
endmodule

bind tick_base_timer tick_base_timer_chk #(
    .CNT_W      (CNT_W),
    .SHORT_BASE (SHORT_BASE),
    .SHORT_STEP (SHORT_STEP)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .short_sel  (short_sel),
    .tone_en    (tone_en),
    .tone_low   (tone_low),
    .long_clr   (long_clr),
    .short_clr  (short_clr),
    .long_flag  (long_flag),
    .short_flag (short_flag),
    .irq        (irq),
    .tone       (tone),
    .cnt        (cnt)
);

// File: tb/test_tick_base_timer.sv
`timescale 1ns/1ps
// Sweep bench: small divider, arithmetic reference count.
module test_tick_base_timer;
    localparam int CW = 8;
    localparam int SB = 2;
    localparam int SS = 1;
    localparam int BB = 1;
    localparam int LONG_P = 1 << CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sub_tick = 0, sys_tick = 0, pre_tick = 0;
    logic [1:0] src_sel = 0, short_sel = 0;
    logic tone_en = 0, tone_low = 0, long_ie = 0, short_ie = 0;
    logic long_clr = 0, short_clr = 0;
    logic long_flag, short_flag, irq, tone;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    int m_n = 0;
    bit m_lf = 0, m_sf = 0, m_rs = 0;
    logic [1:0] m_src = 0;

    always #10 clk = ~clk;

    tick_base_timer #(
        .CNT_W(CW), .SHORT_BASE(SB), .SHORT_STEP(SS), .BUZ_BASE(BB)
    ) i_tick_base_timer (
        .clk(clk), .rst_n(rst_n),
        .sub_tick(sub_tick), .sys_tick(sys_tick), .pre_tick(pre_tick),
        .src_sel(src_sel), .short_sel(short_sel),
        .tone_en(tone_en), .tone_low(tone_low),
        .long_ie(long_ie), .short_ie(short_ie),
        .long_clr(long_clr), .short_clr(short_clr),
        .long_flag(long_flag), .short_flag(short_flag),
        .irq(irq), .tone(tone)
    );

    // Reference model, advanced at each edge from the stable inputs.
    always @(posedge clk) begin
        bit tk, lev, sev;
        int sp;
        if (!rst_n) begin
            m_n = 0; m_lf = 0; m_sf = 0; m_src = 0; m_rs = 0;
        end else if (src_sel != m_src) begin
            // R5: source change clears the count, ignores ticks
            m_n = 0; m_src = src_sel; m_rs = 1;
            if (long_clr)  m_lf = 0;
            if (short_clr) m_sf = 0;
        end else begin
            m_rs = 0;
            // R2: only the registered source counts; code 3 stops
            case (m_src)
                2'd0: tk = sub_tick;
                2'd1: tk = sys_tick;
                2'd2: tk = pre_tick;
                default: tk = 0;
            endcase
            sp  = 1 << (SB + SS * int'(short_sel));
            lev = tk && (m_n == LONG_P - 1);
            sev = tk && ((m_n % sp) == sp - 1);
            if (tk) m_n = (m_n + 1) % LONG_P;
            // R8: set wins over clear
            if (lev) m_lf = 1; else if (long_clr)  m_lf = 0;
            if (sev) m_sf = 1; else if (short_clr) m_sf = 0;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Advance one clock and compare all outputs half a cycle later.
    task automatic cycle();
        bit bit_v;
        @(posedge clk);
        @(negedge clk);
        if (!rst_n) begin
            chk("R1 long", long_flag, 1'b0);
            chk("R1 short", short_flag, 1'b0);
            chk("R1 irq", irq, 1'b0);
            chk("R1 tone", tone, 1'b0);
        end else begin
            bit_v = ((m_n >> (BB + (tone_low ? 1 : 0))) & 1) != 0;
            chk(m_rs ? "R5 long" : "R3 R8 long", long_flag, m_lf);
            chk(m_rs ? "R5 short" : "R4 R8 short", short_flag, m_sf);
            chk("R9 irq", irq, (m_lf && long_ie) || (m_sf && short_ie));
            if (tone_en) chk("R6 tone", tone, bit_v);
            else         chk("R7 tone", tone, 1'b0);
        end
    endtask

    task automatic rand_inputs();
        sub_tick  = ($urandom % 4) != 0;
        sys_tick  = ($urandom % 4) != 0;
        pre_tick  = ($urandom % 4) != 0;
        long_clr  = ($urandom % 24) == 0;
        short_clr = ($urandom % 12) == 0;
    endtask

    initial begin
        void'($urandom(11));
        // R1: tone enabled during reset must still read low
        tone_en = 1; long_ie = 1; short_ie = 1;
        sub_tick = 1; sys_tick = 1; pre_tick = 1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cycle();
        rst_n = 1;
        // Main sweep over source, short period, pitch and enables.
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int b = 0; b < 2; b++) begin
                    src_sel   = 2'(s);
                    short_sel = 2'(p);
                    tone_low  = b[0];
                    tone_en   = (p != 1);
                    long_ie   = p[0];
                    short_ie  = p[1] ^ b[0];
                    for (int c = 0; c < 600; c++) begin
                        rand_inputs();
                        cycle();
                    end
                end
            end
        end
        // R5: frequent source hopping with live short period changes.
        tone_en = 1; long_ie = 1; short_ie = 1;
        for (int c = 0; c < 3000; c++) begin
            rand_inputs();
            if (c % 37 == 0) src_sel = 2'($urandom % 3);
            if (c % 53 == 0) short_sel = 2'($urandom % 4);
            cycle();
        end
        // R1: reset in mid-run.
        rst_n = 0;
        cycle();
        rst_n = 1;
        for (int c = 0; c < 300; c++) begin
            rand_inputs();
            cycle();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule